// File: doc/BRIEF.md
# Complementary PWM Output Stage with Break

This block sits between a timer channel's reference waveform and two output pads. From the reference it makes a main output and a complementary output. Each output has its own driven value and its own output-enable, so the pad can be left floating. A master enable, a run off-drive bit, an idle off-drive bit, two per-output enables, two polarity bits and two idle-level bits set what each output does. When both outputs are enabled, a programmable dead-time separates their active phases. A break input clears the master enable asynchronously. The outputs then fall to their polarity (inactive) levels without waiting for a clock edge. If the clock is running, they move on to their idle levels.

Three small pieces do the work. A combinational decoder turns the five control bits into an output mode for each pin: floating, inactive drive, direct drive, dead-time drive or idle drive. The dead-time state machine has four states: `DT_COMP_ON` (complementary phase active), `DT_GAP_MAIN` (gap counting before the main phase), `DT_MAIN_ON` (main phase active) and `DT_GAP_COMP` (gap counting before the complementary phase). A reference high moves `DT_COMP_ON` or `DT_GAP_COMP` toward the main phase. A reference low moves `DT_MAIN_ON` or `DT_GAP_MAIN` toward the complementary phase. A gap state ends when its counter reaches zero. The idle sequencer has three states: `IS_RUN` (master enable set), `IS_SAFE` (counting the dead-time after disarm) and `IS_IDLE` (idle levels applied). `IS_RUN` goes to `IS_SAFE`, or straight to `IS_IDLE` when the dead-time is zero, once the master enable is seen low. `IS_SAFE` goes to `IS_IDLE` when its count expires. Either state goes back to `IS_RUN` when the master enable is seen high.

Top module: `cpwm_out_stage`

## Requirements
- R1: After reset the master enable is clear and, with the idle off-drive bit clear, both outputs float (oe=0, value 0).
- R2: With the master enable set and both output enables clear, both outputs float with value 0, whatever the run off-drive bit is.
- R3: With the master enable set, exactly one output enable set and run off-drive clear, the enabled output drives `ref_in` XOR its polarity bit combinationally, and the other output floats with value 0.
- R4: Under the conditions of R3 but with run off-drive set, the disabled output is driven at its polarity bit instead of floating.
- R5: With the master enable set and both output enables set, main drives dead-time-main XOR its polarity bit. Main becomes active after edge k+dtime when `ref_in` is first sampled high at edge k, and the complementary output becomes inactive right after edge k.
- R6: In that mode, the complementary output drives dead-time-comp XOR its polarity bit and becomes active after edge k+dtime when `ref_in` is first sampled low at edge k. Main becomes inactive right after edge k.
- R7: Two driven outputs are never both at their active level (active means value differs from polarity). A reference pulse shorter than the dead-time never activates either output.
- R8: With the master enable clear, both outputs float if the idle off-drive bit is clear, or if both output enables are clear.
- R9: With the master enable clear, idle off-drive set and at least one output enable set, both outputs are driven at their polarity bits at once with no clock edge needed. After the (dtime+1)-th edge that samples the master enable low, they change to their idle-level bits.
- R10: If both idle levels would be active, the complementary output is held at its polarity bit in the idle state.
- R11: `break_in` high clears the master enable asynchronously, and a write that would set it while break is high has no effect.
- R12: The master enable takes `arm_wdata` at a rising clock edge where `arm_wr` is high and `break_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference PWM waveform |
| break_in | input | 1 | Break, active high, disarms asynchronously |
| arm_wr | input | 1 | Master enable write strobe |
| arm_wdata | input | 1 | Master enable write value |
| run_off_drive | input | 1 | Drive disabled outputs inactive while armed |
| idle_off_drive | input | 1 | Drive outputs while disarmed |
| main_en | input | 1 | Main output enable bit |
| comp_en | input | 1 | Complementary output enable bit |
| main_pol | input | 1 | Main polarity (its inactive level) |
| comp_pol | input | 1 | Complementary polarity (its inactive level) |
| main_idle | input | 1 | Main idle level |
| comp_idle | input | 1 | Complementary idle level |
| dtime | input | DT_W | Dead-time in clock cycles |
| main_out | output | 1 | Main output value |
| main_oe | output | 1 | Main output enable |
| comp_out | output | 1 | Complementary output value |
| comp_oe | output | 1 | Complementary output enable |

## Verification
The decoded modes (floating, inactive, direct) and the immediate safe levels after a break follow the inputs combinationally. The bench checks them one time step after it changes an input, with no clock edge in between. Dead-time edges are due exactly dtime edges after the edge that first samples the new reference level, and idle levels are due dtime+1 edges after the first edge that sees the master enable low. The bench changes inputs 5 ns after a rising edge, counts edges with a tick task, and checks the cycle just before each expected change as well as the cycle of the change, so that an off-by-one count is caught.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [2:0] {
        OM_HIZ,
        OM_INACT,
        OM_DIRECT,
        OM_DEAD,
        OM_IDLE
    } out_mode_e;

    typedef enum logic [1:0] {
        DT_COMP_ON,
        DT_GAP_MAIN,
        DT_MAIN_ON,
        DT_GAP_COMP
    } dt_state_e;

    typedef enum logic [1:0] {
        IS_RUN,
        IS_SAFE,
        IS_IDLE
    } idle_state_e;

endpackage

// File: rtl/cpwm_ctrl_decode.sv
module cpwm_ctrl_decode
    import cpwm_pkg::*;
(
    input  logic      arm,
    input  logic      idle_off_drive,
    input  logic      run_off_drive,
    input  logic      main_en,
    input  logic      comp_en,
    input  logic      idle_act,
    output out_mode_e mode_main,
    output out_mode_e mode_comp
);

    out_mode_e off_mode;

    always_comb begin
        off_mode  = run_off_drive ? OM_INACT : OM_HIZ;
        mode_main = OM_HIZ;
        mode_comp = OM_HIZ;
        if (arm) begin
            unique case ({main_en, comp_en})
                2'b00: begin
                    mode_main = OM_HIZ;
                    mode_comp = OM_HIZ;
                end
                2'b01: begin
                    mode_main = off_mode;
                    mode_comp = OM_DIRECT;
                end
                2'b10: begin
                    mode_main = OM_DIRECT;
                    mode_comp = off_mode;
                end
                2'b11: begin
                    mode_main = OM_DEAD;
                    mode_comp = OM_DEAD;
                end
            endcase
        end else if (idle_off_drive && (main_en || comp_en)) begin
            mode_main = idle_act ? OM_IDLE : OM_INACT;
            mode_comp = idle_act ? OM_IDLE : OM_INACT;
        end
    end

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
    import cpwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_in,
    input  logic [DT_W-1:0] dtime,
    output logic            dt_main,
    output logic            dt_comp
);

    localparam logic [DT_W-1:0] CNT_ZERO = '0;
    localparam logic [DT_W-1:0] CNT_ONE  = DT_W'(1);

    dt_state_e       st_q, st_d;
    logic [DT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DT_COMP_ON;
            cnt_q <= CNT_ZERO;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DT_COMP_ON, DT_GAP_COMP: begin
                if (ref_in) begin
                    if (dtime == CNT_ZERO) begin
                        st_d = DT_MAIN_ON;
                    end else begin
                        st_d  = DT_GAP_MAIN;
                        cnt_d = dtime - CNT_ONE;
                    end
                end else if (st_q == DT_GAP_COMP) begin
                    if (cnt_q == CNT_ZERO) st_d = DT_COMP_ON;
                    else                   cnt_d = cnt_q - CNT_ONE;
                end
            end
            DT_MAIN_ON, DT_GAP_MAIN: begin
                if (!ref_in) begin
                    if (dtime == CNT_ZERO) begin
                        st_d = DT_COMP_ON;
                    end else begin
                        st_d  = DT_GAP_COMP;
                        cnt_d = dtime - CNT_ONE;
                    end
                end else if (st_q == DT_GAP_MAIN) begin
                    if (cnt_q == CNT_ZERO) st_d = DT_MAIN_ON;
                    else                   cnt_d = cnt_q - CNT_ONE;
                end
            end
        endcase
    end

    always_comb begin
        dt_main = (st_q == DT_MAIN_ON);
        dt_comp = (st_q == DT_COMP_ON);
    end

    // R5: the main phase only ever follows a sampled-high reference
    p_main_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dt_main |-> $past(ref_in));

    // R6: the complementary phase only starts after a sampled-low reference
    p_comp_after_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dt_comp) |-> !$past(ref_in));

endmodule

// File: rtl/cpwm_idle_seq.sv
module cpwm_idle_seq
    import cpwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [DT_W-1:0] dtime,
    output logic            idle_act
);

    localparam logic [DT_W-1:0] CNT_ZERO = '0;
    localparam logic [DT_W-1:0] CNT_ONE  = DT_W'(1);

    idle_state_e     st_q, st_d;
    logic [DT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= IS_IDLE;
            cnt_q <= CNT_ZERO;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            IS_RUN: begin
                if (!arm) begin
                    if (dtime == CNT_ZERO) begin
                        st_d = IS_IDLE;
                    end else begin
                        st_d  = IS_SAFE;
                        cnt_d = dtime - CNT_ONE;
                    end
                end
            end
            IS_SAFE: begin
                if (arm)                    st_d = IS_RUN;
                else if (cnt_q == CNT_ZERO) st_d = IS_IDLE;
                else                        cnt_d = cnt_q - CNT_ONE;
            end
            IS_IDLE: begin
                if (arm) st_d = IS_RUN;
            end
            default: st_d = IS_IDLE;
        endcase
    end

    always_comb begin
        idle_act = (st_q == IS_IDLE);
    end

    // R9: idle levels are reached only after the enable was seen low
    p_idle_needs_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == IS_IDLE) |-> !$past(arm));

    // R9: a sampled-high enable always returns the sequencer to run
    p_arm_returns_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (st_q == IS_RUN));

endmodule

// File: rtl/cpwm_out_stage.sv
module cpwm_out_stage
    import cpwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_in,
    input  logic            break_in,
    input  logic            arm_wr,
    input  logic            arm_wdata,
    input  logic            run_off_drive,
    input  logic            idle_off_drive,
    input  logic            main_en,
    input  logic            comp_en,
    input  logic            main_pol,
    input  logic            comp_pol,
    input  logic            main_idle,
    input  logic            comp_idle,
    input  logic [DT_W-1:0] dtime,
    output logic            main_out,
    output logic            main_oe,
    output logic            comp_out,
    output logic            comp_oe
);

    logic      arm_q;
    logic      dt_main, dt_comp;
    logic      idle_act;
    logic      comp_idle_safe;
    out_mode_e mode_main, mode_comp;

    // master enable: break clears it without a clock
    always_ff @(posedge clk or negedge rst_n or posedge break_in) begin
        if (!rst_n)        arm_q <= 1'b0;
        else if (break_in) arm_q <= 1'b0;
        else if (arm_wr)   arm_q <= arm_wdata;
    end

    cpwm_ctrl_decode u_decode (
        .arm            (arm_q),
        .idle_off_drive (idle_off_drive),
        .run_off_drive  (run_off_drive),
        .main_en        (main_en),
        .comp_en        (comp_en),
        .idle_act       (idle_act),
        .mode_main      (mode_main),
        .mode_comp      (mode_comp)
    );

    cpwm_deadtime #(.DT_W(DT_W)) u_deadtime (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_in  (ref_in),
        .dtime   (dtime),
        .dt_main (dt_main),
        .dt_comp (dt_comp)
    );

    cpwm_idle_seq #(.DT_W(DT_W)) u_idle_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm_q),
        .dtime    (dtime),
        .idle_act (idle_act)
    );

    function automatic logic [1:0] pin_drive(out_mode_e m, logic direct,
                                             logic dead, logic pol, logic idle);
        case (m)
            OM_INACT:  return {1'b1, pol};
            OM_DIRECT: return {1'b1, direct ^ pol};
            OM_DEAD:   return {1'b1, dead ^ pol};
            OM_IDLE:   return {1'b1, idle};
            default:   return 2'b00;
        endcase
    endfunction

    always_comb begin
        // both idle levels active: keep the complementary pin inactive
        comp_idle_safe = ((main_idle != main_pol) && (comp_idle != comp_pol))
                         ? comp_pol : comp_idle;
        {main_oe, main_out} = pin_drive(mode_main, ref_in, dt_main, main_pol, main_idle);
        {comp_oe, comp_out} = pin_drive(mode_comp, ref_in, dt_comp, comp_pol, comp_idle_safe);
    end

    p_no_both_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (main_oe && comp_oe) |-> !((main_out != main_pol) && (comp_out != comp_pol)));

    p_off_floats_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_q && !idle_off_drive) |-> (!main_oe && !comp_oe));

    p_break_disarms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        break_in |-> !arm_q);

    p_run_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && run_off_drive && main_en && !comp_en)
            |-> (comp_oe && (comp_out == comp_pol)));

endmodule

// File: tb/test_cpwm_out_stage.sv
module test_cpwm_out_stage;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_in, break_in, arm_wr, arm_wdata;
    logic       run_off_drive, idle_off_drive, main_en, comp_en;
    logic       main_pol, comp_pol, main_idle, comp_idle;
    logic [7:0] dtime;
    logic       main_out, main_oe, comp_out, comp_oe;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cpwm_out_stage #(.DT_W(8)) i_cpwm_out_stage (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .break_in(break_in),
        .arm_wr(arm_wr), .arm_wdata(arm_wdata),
        .run_off_drive(run_off_drive), .idle_off_drive(idle_off_drive),
        .main_en(main_en), .comp_en(comp_en),
        .main_pol(main_pol), .comp_pol(comp_pol),
        .main_idle(main_idle), .comp_idle(comp_idle), .dtime(dtime),
        .main_out(main_out), .main_oe(main_oe),
        .comp_out(comp_out), .comp_oe(comp_oe)
    );

    // {main_oe, main_out, comp_oe, comp_out}
    function automatic logic [3:0] pins();
        return {main_oe, main_out, comp_oe, comp_out};
    endfunction

    task automatic check(string req, logic [3:0] exp);
        logic [3:0] act;
        act = pins();
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s pins act=%b exp=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic set_ctrl(logic ro, logic io, logic me, logic ce, logic mp,
                            logic cp, logic mi, logic ci, logic [7:0] dt);
        run_off_drive = ro; idle_off_drive = io; main_en = me; comp_en = ce;
        main_pol = mp; comp_pol = cp; main_idle = mi; comp_idle = ci; dtime = dt;
    endtask

    task automatic write_arm(logic v);
        arm_wr = 1'b1; arm_wdata = v;
        tick();
        arm_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ref_in = 1'b0; break_in = 1'b0; arm_wr = 1'b0; arm_wdata = 1'b0;
        set_ctrl(1, 0, 1, 1, 0, 0, 0, 0, 8'd0);
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check("R1", 4'b0000);
        ref_in = 1'b1; #1;
        check("R8", 4'b0000);
        set_ctrl(0, 1, 0, 0, 1, 1, 1, 1, 8'd0); #1;
        check("R8", 4'b0000);
        ref_in = 1'b0;
    endtask

    task automatic t_single();
        set_ctrl(0, 0, 1, 0, 0, 0, 0, 0, 8'd0);
        ref_in = 1'b1;
        write_arm(1'b1);
        check("R12", 4'b1100);
        ref_in = 1'b0; #1;
        check("R3", 4'b1000);
        main_pol = 1'b1; #1;
        check("R3", 4'b1100);
        set_ctrl(0, 0, 0, 1, 0, 1, 0, 0, 8'd0); ref_in = 1'b1; #1;
        check("R3", 4'b0010);
        run_off_drive = 1'b1; main_pol = 1'b1; #1;
        check("R4", 4'b1110);
        set_ctrl(1, 0, 1, 0, 0, 1, 0, 0, 8'd0); #1;
        check("R4", 4'b1111);
        set_ctrl(1, 0, 0, 0, 0, 0, 0, 0, 8'd0); #1;
        check("R2", 4'b0000);
        run_off_drive = 1'b0; #1;
        check("R2", 4'b0000);
    endtask

    task automatic t_dead();
        set_ctrl(0, 0, 1, 1, 0, 0, 0, 0, 8'd3);
        ref_in = 1'b0;
        tick(6);
        check("R6", 4'b1011);
        ref_in = 1'b1;
        tick();
        check("R5", 4'b1010);
        tick(2);
        check("R5", 4'b1010);
        tick();
        check("R5", 4'b1110);
        ref_in = 1'b0;
        tick();
        check("R6", 4'b1010);
        tick(2);
        check("R6", 4'b1010);
        tick();
        check("R6", 4'b1011);
        dtime = 8'd0; ref_in = 1'b1;
        tick();
        check("R5", 4'b1110);
        ref_in = 1'b0;
        tick();
        check("R6", 4'b1011);
        main_pol = 1'b1; comp_pol = 1'b1; #1;
        check("R6", 4'b1110);
        main_pol = 1'b0; comp_pol = 1'b0;
        // pulse shorter than the dead-time never activates an output
        dtime = 8'd4; ref_in = 1'b1;
        tick(2);
        ref_in = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R7", 4'b1010);
        end
        tick();
        check("R7", 4'b1011);
    endtask

    task automatic t_break();
        set_ctrl(0, 1, 1, 1, 0, 1, 0, 0, 8'd2);
        ref_in = 1'b1;
        tick(4);
        check("R5", 4'b1111);
        break_in = 1'b1; #1;
        check("R11", 4'b1011);
        tick();
        check("R9", 4'b1011);
        tick();
        check("R9", 4'b1011);
        tick();
        check("R9", 4'b1010);
        write_arm(1'b1);
        check("R11", 4'b1010);
        tick();
        check("R11", 4'b1010);
        break_in = 1'b0;
        write_arm(1'b1);
        check("R12", 4'b1111);
        dtime = 8'd0;
        write_arm(1'b0);
        check("R9", 4'b1011);
        tick();
        check("R9", 4'b1010);
        set_ctrl(0, 1, 1, 0, 0, 0, 1, 1, 8'd0); #1;
        check("R10", 4'b1110);
        set_ctrl(0, 0, 1, 1, 0, 0, 1, 1, 8'd0); #1;
        check("R8", 4'b0000);
    endtask

    initial begin
        t_reset();
        t_single();
        t_dead();
        t_break();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule